// File: doc/BRIEF.md
# Counter-Acknowledged Interrupt Mask Hub

The hub merges the interrupt requests of one overview source and up to fifteen controller cores into one level-sensitive interrupt line. Each source owns a free-running event counter that is published on an output. Software keeps its own copy of how far it has processed each source and writes that counter value back into the source's acknowledge register. A source is pending while its published counter and its acknowledged value differ, so events that arrive between the read and the acknowledge are never lost.

Masking is done through one command word holding a two-bit field per source. One code masks, another unmasks, and the two remaining codes leave the source alone. A single write can therefore change any subset of sources without a read-modify-write. The low byte of each core's counter doubles as the head index of that core's 256-entry message ring and is presented separately.

Top module: `irq_mask_ack_hub`

## Requirements
- R1: After reset every counter and every acknowledge value is zero, every source is masked and `irq_o` is low.
- R2: An event pulse on a source increments that source's counter by one at the next clock edge, modulo 2^CNT_W, whether or not the source is masked; without a pulse the counter holds.
- R3: Source 0 is the overview source and core n is source n+1; the command field of source s sits at bits [2s+1:2s] of the command word.
- R4: In a written command word a field of 2'b01 unmasks its source, 2'b10 masks it, and 2'b00 or 2'b11 leaves its mask unchanged.
- R5: Writing 32'h5555_5555 with the default of fifteen cores unmasks all sixteen sources in one write.
- R6: An acknowledge write stores `ack_data_i` as the acknowledge value of the source selected by `ack_sel_i` at the next edge; other sources are unaffected.
- R7: A source is pending when its counter differs from its acknowledge value, in either direction; a counter that wraps back to the acknowledged value is not pending.
- R8: `irq_o` is high exactly when at least one source is both unmasked and pending, and it follows the state updated at the previous edge.
- R9: Events counted while masked and not acknowledged raise `irq_o` as soon as the source is unmasked.
- R10: `ring_head_o[8n+7:8n]` equals the low eight bits of the counter of core n.
- R11: An event and an acknowledge on the same source in the same cycle both take effect: the counter increments and the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CORES+1 | One-cycle event pulse per source, bit 0 = overview |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_data_i | input | 2*(NUM_CORES+1) | Command word, two bits per source |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_sel_i | input | clog2(NUM_CORES+1) | Source selected by the acknowledge write |
| ack_data_i | input | CNT_W | Processed counter value being acknowledged |
| cnt_o | output | (NUM_CORES+1)*CNT_W | Published event counters, source s at [s*CNT_W +: CNT_W] |
| ring_head_o | output | NUM_CORES*8 | Ring head index per core |
| mask_o | output | NUM_CORES+1 | Current mask bit per source, 1 = masked |
| irq_o | output | 1 | Level-sensitive shared interrupt |

## Verification
Every input is sampled at one rising edge and every result (counter, mask bit, acknowledge effect, ring head and the interrupt line) is visible right after that same edge, a latency of one edge with no further pipeline. The bench drives each stimulus on a falling edge, holds it across exactly one rising edge, then removes it and compares all outputs against its own arithmetic model at the following falling edge. Because the model is advanced by the same one-edge rule, a result arriving a cycle early or late shows up as a mismatch.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   localparam int unsigned HEAD_W    = 8;
   localparam int unsigned MAX_CORES = 15;

   typedef enum logic [1:0] {
      CMD_IDLE_LO = 2'b00,
      CMD_UNMASK  = 2'b01,
      CMD_MASK    = 2'b10,
      CMD_IDLE_HI = 2'b11
   } src_cmd_e;

   typedef struct packed {
      logic mask_set;
      logic mask_clr;
   } mask_op_t;

   function automatic mask_op_t decode_field(input logic [1:0] field);
      mask_op_t op;
      op = '0;
      case (src_cmd_e'(field))
         CMD_MASK:   op.mask_set = 1'b1;
         CMD_UNMASK: op.mask_clr = 1'b1;
         default:    op = '0;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/irq_hub_cmd_dec.sv
module irq_hub_cmd_dec
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16
) (
   input  logic                   cmd_we_i,
   input  logic [2*NUM_SRC-1:0]   cmd_data_i,
   output logic [NUM_SRC-1:0]     mask_set_o,
   output logic [NUM_SRC-1:0]     mask_clr_o
);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
      mask_op_t op;
      assign op            = decode_field(cmd_data_i[2*s +: 2]);
      assign mask_set_o[s] = cmd_we_i & op.mask_set;
      assign mask_clr_o[s] = cmd_we_i & op.mask_clr;
   end

endmodule

// File: rtl/irq_hub_src_slice.sv
module irq_hub_src_slice #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             mask_set_i,
   input  logic             mask_clr_i,
   input  logic             ack_we_i,
   input  logic [CNT_W-1:0] ack_data_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             masked_o,
   output logic             live_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ack_q;
   logic             mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (evt_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= '0;
      end else if (ack_we_i) begin
         ack_q <= ack_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
      end else if (mask_set_i) begin
         mask_q <= 1'b1;
      end else if (mask_clr_i) begin
         mask_q <= 1'b0;
      end
   end

   assign cnt_o    = cnt_q;
   assign masked_o = mask_q;
   assign live_o   = (cnt_q != ack_q) & ~mask_q;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R2
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_i |=> $stable(cnt_o)); // R2
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we_i && !evt_i && (ack_data_i == cnt_o)) |=> !live_o); // R6
   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      mask_set_i |=> masked_o); // R4
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_clr_i && !mask_set_i) |=> !masked_o); // R4
   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_set_i && !mask_clr_i) |=> $stable(masked_o)); // R4

endmodule

// File: rtl/irq_hub_or_tree.sv
module irq_hub_or_tree #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] req_i,
   output logic         any_o
);

   localparam int unsigned LEVELS = $clog2(N);
   localparam int unsigned LEAVES = 1 << LEVELS;

   logic [2*LEAVES-1:1] node;

   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < N) begin : g_used
         assign node[LEAVES+i] = req_i[i];
      end else begin : g_pad
         assign node[LEAVES+i] = 1'b0;
      end
   end

   for (genvar k = 1; k < LEAVES; k++) begin : g_inner
      assign node[k] = node[2*k] | node[2*k+1];
   end

   assign any_o = node[1];

endmodule

// File: rtl/irq_mask_ack_hub.sv
module irq_mask_ack_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_CORES = 15,
   parameter int unsigned CNT_W     = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [NUM_CORES:0]                    evt_i,
   input  logic                                  cmd_we_i,
   input  logic [2*NUM_CORES+1:0]                cmd_data_i,
   input  logic                                  ack_we_i,
   input  logic [$clog2(NUM_CORES+1)-1:0]        ack_sel_i,
   input  logic [CNT_W-1:0]                      ack_data_i,
   output logic [(NUM_CORES+1)*CNT_W-1:0]        cnt_o,
   output logic [NUM_CORES*HEAD_W-1:0]           ring_head_o,
   output logic [NUM_CORES:0]                    mask_o,
   output logic                                  irq_o
);

   localparam int unsigned NUM_SRC = NUM_CORES + 1;
   localparam int unsigned SEL_W   = $clog2(NUM_SRC);

   if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cores
      $error("irq_mask_ack_hub: NUM_CORES out of range");
   end
   if (CNT_W < HEAD_W) begin : g_bad_cnt
      $error("irq_mask_ack_hub: CNT_W narrower than ring head index");
   end

   logic [NUM_SRC-1:0] mask_set;
   logic [NUM_SRC-1:0] mask_clr;
   logic [NUM_SRC-1:0] ack_hit;
   logic [NUM_SRC-1:0] live;

   irq_hub_cmd_dec #(
      .NUM_SRC (NUM_SRC)
   ) cmd_dec_i (
      .cmd_we_i   (cmd_we_i),
      .cmd_data_i (cmd_data_i),
      .mask_set_o (mask_set),
      .mask_clr_o (mask_clr)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign ack_hit[s] = ack_we_i && (ack_sel_i == SEL_W'(s));

      irq_hub_src_slice #(
         .CNT_W (CNT_W)
      ) slice_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .evt_i      (evt_i[s]),
         .mask_set_i (mask_set[s]),
         .mask_clr_i (mask_clr[s]),
         .ack_we_i   (ack_hit[s]),
         .ack_data_i (ack_data_i),
         .cnt_o      (cnt_o[s*CNT_W +: CNT_W]),
         .masked_o   (mask_o[s]),
         .live_o     (live[s])
      );
   end

   for (genvar n = 0; n < NUM_CORES; n++) begin : g_head
      assign ring_head_o[n*HEAD_W +: HEAD_W] = cnt_o[(n+1)*CNT_W +: HEAD_W];
   end

   irq_hub_or_tree #(
      .N (NUM_SRC)
   ) or_tree_i (
      .req_i (live),
      .any_o (irq_o)
   );

   AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !(&mask_o)); // R8
   AST_ALL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we_i && (&mask_set)) |=> !irq_o); // R4

endmodule

// File: tb/irq_mask_ack_hub_tb_top.sv
module irq_mask_ack_hub_tb_top;

   localparam int unsigned NC     = 15;
   localparam int unsigned NS     = NC + 1;
   localparam int unsigned CW     = 10;
   localparam int unsigned CMAX   = (1 << CW) - 1;
   localparam time         CLK_PERIOD = 10ns;
   localparam int unsigned WD_CYCLES  = 60000;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NS-1:0]        evt = '0;
   logic                 cmd_we = 1'b0;
   logic [2*NS-1:0]      cmd = '0;
   logic                 ack_we = 1'b0;
   logic [3:0]           ack_sel = '0;
   logic [CW-1:0]        ack_data = '0;
   logic [NS*CW-1:0]     cnt_o;
   logic [NC*8-1:0]      head_o;
   logic [NS-1:0]        mask_o;
   logic                 irq_o;

   int unsigned total = 0;
   int unsigned bad   = 0;
   bit          done  = 1'b0;

   int unsigned m_cnt [NS];
   int unsigned m_ack [NS];
   bit          m_mask[NS];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_mask_ack_hub #(
      .NUM_CORES (NC),
      .CNT_W     (CW)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .cmd_we_i    (cmd_we),
      .cmd_data_i  (cmd),
      .ack_we_i    (ack_we),
      .ack_sel_i   (ack_sel),
      .ack_data_i  (ack_data),
      .cnt_o       (cnt_o),
      .ring_head_o (head_o),
      .mask_o      (mask_o),
      .irq_o       (irq_o)
   );

   task automatic chk(input string tag, input string what, input int unsigned act,
                      input int unsigned exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic bit exp_irq();
      bit r = 1'b0;
      for (int s = 0; s < NS; s++)
         if (!m_mask[s] && (m_cnt[s] != m_ack[s])) r = 1'b1;
      return r;
   endfunction

   task automatic check_all(input string tag);
      for (int s = 0; s < NS; s++) begin
         chk(tag, $sformatf("cnt[%0d]", s), cnt_o[s*CW +: CW], m_cnt[s]);
         chk(tag, $sformatf("mask[%0d]", s), mask_o[s], m_mask[s]);
      end
      for (int n = 0; n < NC; n++)
         chk("R10", $sformatf("head[%0d]", n), head_o[n*8 +: 8], m_cnt[n+1] & 8'hFF);
      chk(tag, "irq", irq_o, exp_irq());
   endtask

   task automatic step(input logic [NS-1:0] ev, input bit cw, input logic [2*NS-1:0] cd,
                       input bit aw, input int sel, input int unsigned ad, input string tag);
      evt = ev; cmd_we = cw; cmd = cd; ack_we = aw; ack_sel = 4'(sel); ack_data = CW'(ad);
      @(negedge clk);
      evt = '0; cmd_we = 1'b0; ack_we = 1'b0;
      for (int s = 0; s < NS; s++) begin
         if (ev[s]) m_cnt[s] = (m_cnt[s] + 1) & CMAX;
         if (aw && sel == s) m_ack[s] = ad & CMAX;
         if (cw) begin
            if (cd[2*s +: 2] == 2'b01) m_mask[s] = 1'b0;
            if (cd[2*s +: 2] == 2'b10) m_mask[s] = 1'b1;
         end
      end
      check_all(tag);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rs;
      for (int s = 0; s < NS; s++) begin m_cnt[s] = 0; m_ack[s] = 0; m_mask[s] = 1'b1; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R2: count while masked, source s gets s+1 events
      for (int s = 0; s < NS; s++)
         for (int k = 0; k <= s; k++) step(NS'(1) << s, 0, '0, 0, 0, 0, "R2");
      step('0, 0, '0, 0, 0, 0, "R2");

      // R3 / R4: per-field placement and codes
      for (int s = 0; s < NS; s++) begin
         step('0, 1, (2*NS)'(2'b01) << (2*s), 0, 0, 0, "R3");
         step('0, 1, (2*NS)'(2'b10) << (2*s), 0, 0, 0, "R4");
      end
      step('0, 1, (2*NS)'(2'b01) << 6, 0, 0, 0, "R4");
      step('0, 1, '1, 0, 0, 0, "R4");
      step('0, 1, '0, 0, 0, 0, "R4");
      step('0, 1, {NS{2'b10}}, 0, 0, 0, "R4");

      // R5: one-shot unmask of all sources
      step('0, 1, 32'h5555_5555, 0, 0, 0, "R5");

      // R6 / R8: acknowledge each source, irq drops only after the last
      for (int s = 0; s < NS; s++) step('0, 0, '0, 1, s, m_cnt[s], "R6");
      step('0, 0, '0, 0, 0, 0, "R8");

      // R7: ack above the counter still pending
      step('0, 0, '0, 1, 2, m_cnt[2] + 1, "R7");
      step('0, 0, '0, 1, 2, m_cnt[2], "R7");
      // R7: full wrap returns to acknowledged value
      for (int k = 0; k < (1 << CW); k++) step(NS'(1) << 4, 0, '0, 0, 0, 0, "R7");

      // R9: masked events, reassert on unmask
      step('0, 1, {NS{2'b10}}, 0, 0, 0, "R9");
      step(NS'(1) << 7 | NS'(1) << 9, 0, '0, 0, 0, 0, "R9");
      step('0, 1, (2*NS)'(2'b01) << 18, 0, 0, 0, "R9");
      step('0, 0, '0, 1, 9, m_cnt[9], "R9");
      step('0, 1, (2*NS)'(2'b01) << 14, 0, 0, 0, "R9");
      step('0, 0, '0, 1, 7, m_cnt[7], "R9");

      // R11: event and ack on the same source together
      step('0, 1, 32'h5555_5555, 0, 0, 0, "R11");
      step(NS'(1) << 5, 0, '0, 1, 5, m_cnt[5], "R11");
      step('0, 0, '0, 1, 5, m_cnt[5], "R11");

      // R8: pseudo-random sweep against the model
      rs = 32'h1234_5678;
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r1, r2;
         int          sel;
         rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5; r1 = rs;
         rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5; r2 = rs;
         sel = int'(r1[27:24]);
         step(NS'(r1[15:0] & r2[15:0] & r1[31:16]), r1[28] & r2[29], r2,
              r1[30], sel, r2[31] ? m_cnt[sel] : int'(r1[9:0]), "R8");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule